// File: doc/BRIEF.md
# I/O Cycle Address Decoder

This block watches the I/O transactions that appear on a PCI-style target bus and decides, for each one, whether this agent claims it. A transaction is sampled on the clock where `frame_start` is high. At that edge the block also samples the start address, the byte enables and the bus command. The start address is compared against two kinds of window. One is a small table of fixed windows with constant bounds, each of which can be switched off. The other is a set of programmable 16-byte windows that can be moved and switched off. A hit in either is claimed by positive decode at medium timing. A cycle that hits nothing can, if enabled, be claimed later by subtractive decode, once every other agent has had its chance to respond.

For every I/O access the block also forms the 17-bit address of the last byte touched. It reports bit 16 of that sum, so an access that runs past 0FFFFh into the three bytes above it is flagged. Together with the claim, the block reports which window won and whether the claimed cycle is to be forwarded downstream. The window configuration sits in a register that reset clears to a defined state and that is loaded by a one-cycle write strobe.

Top module: `io_claim_decoder`

## Requirements
- R1: During and after reset, `claim`, `forward` and `wrap` are 0 and `hit_idx` is 6 (no window). After reset all four fixed windows are enabled, both variable windows are disabled with base 0, and subtractive decode is off.
- R2: On a `frame_start` edge, `wrap` is loaded with bit 16 of the 17-bit sum addr + n − 1. Here n is the number of set bits in `be`, and n = 0 is treated as 1. Example: start FFFDh with 4 bytes gives 1, start FFFCh with 4 bytes gives 0, start FFFFh with 2 bytes gives 1.
- R3: An I/O cycle (cmd 0010b read or 0011b write) whose start address lies in an enabled window is claimed by a one-cycle `claim` pulse. If the frame is sampled at edge 0, the pulse is registered at edge 2.
- R4: A fixed window whose enable bit is 0 is not positively decoded. The fixed windows are index 0 at 000h–00Fh, index 1 at 020h–03Fh, index 2 at 070h–077h and index 3 at 0F0h–0FFh.
- R5: Variable window j hits when its enable bit is 1 and address bits [15:4] equal bits [15:4] of its base. Writing a new base moves the window.
- R6: `hit_idx` is registered at the frame edge. Its values are: 0–3 for a fixed window, 4 + j for variable window j, and 6 for no hit. Fixed windows take precedence over variable windows, and a lower variable index takes precedence over a higher one.
- R7: With subtractive decode enabled, an I/O cycle that hits no window is claimed by a one-cycle pulse registered at edge 4. This happens only if `ext_claim` was low at edges 1 through 4.
- R8: `ext_claim` high at any of edges 1–4 suppresses a subtractive claim. It has no effect on a positive claim.
- R9: `forward` is cleared at every frame edge and loaded at the claim edge. Fixed windows 0 and 1 give 0. Fixed windows 2 and 3, variable windows and subtractive claims give 1.
- R10: A frame with any command other than I/O read or write, configuration commands included, is never claimed and sets `hit_idx` to 6.
- R11: A new `frame_start` abandons any decode still in progress. Only the new frame can then be claimed.
- R12: A `cfg_we` pulse loads all configuration fields at that edge. The new values apply to frames sampled at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Address phase strobe; addr, be and cmd are valid with it |
| addr | input | 16 | Start byte address of the access |
| be | input | 4 | Byte enables; the count of set bits gives the access length |
| cmd | input | 4 | Bus command |
| ext_claim | input | 1 | Another agent has claimed the current cycle |
| cfg_we | input | 1 | Load strobe for the configuration register |
| cfg_fix_en | input | 4 | Per-window enables for the fixed windows |
| cfg_var_en | input | 2 | Per-window enables for the variable windows |
| cfg_var_base | input | 32 | Variable window bases, window j in bits [16j+15:16j] |
| cfg_sub_en | input | 1 | Subtractive decode enable |
| claim | output | 1 | One-cycle claim pulse |
| hit_idx | output | 3 | Winning window of the latest frame |
| forward | output | 1 | Claimed cycle goes downstream |
| wrap | output | 1 | Bit 16 of the last byte address of the latest frame |

## Verification
Addresses are placed inside, at and just beyond the fixed bounds. This separates the range comparison from an off-by-one error and from a swapped window. The fixed windows are also disabled and variable windows are placed on top of them, which shows that the precedence order is applied and that the enable bit acts. Accesses near 0FFFFh with lengths 1, 2 and 4 distinguish a true 17-bit carry from a length count that is off by one. Misses are sent with and without a competing claim at various edges, and some are cut short by a new frame. These cases separate the positive timing from the subtractive timing and show that suppression and abandonment take effect.

// File: rtl/iodec_pkg.sv
// Shared constants for the I/O cycle decoder: bus command codes and the
// fixed window table. Assumes fixed windows do not overlap one another.
package iodec_pkg;

    localparam int NFIX = 4;

    localparam logic [3:0] CMD_IO_RD = 4'b0010;
    localparam logic [3:0] CMD_IO_WR = 4'b0011;

    // Lower bound of fixed window i
    function automatic logic [15:0] fix_lo(input int i);
        case (i)
            0:       return 16'h0000;
            1:       return 16'h0020;
            2:       return 16'h0070;
            default: return 16'h00F0;
        endcase
    endfunction

    // Upper bound (inclusive) of fixed window i
    function automatic logic [15:0] fix_hi(input int i);
        case (i)
            0:       return 16'h000F;
            1:       return 16'h003F;
            2:       return 16'h0077;
            default: return 16'h00FF;
        endcase
    endfunction

    // Whether a claim through fixed window i is passed downstream
    function automatic logic fix_fwd(input int i);
        return (i >= 2);
    endfunction

endpackage

// File: rtl/iodec_span.sv
// Access span: forms the address of the last byte of an access, one bit
// wider than the address, and reports its top bit. Assumes the byte
// enables describe a contiguous access whose length is their bit count.
module iodec_span #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [3:0]    be,
    output logic [AW:0]   last_byte,
    output logic          wrap
);
    logic [2:0] nbytes;
    logic [2:0] nbytes_m1;

    // Length from the enables, an empty mask counting as one byte
    always_comb begin
        nbytes    = 3'($countones(be));
        nbytes_m1 = (nbytes == 3'd0) ? 3'd0 : nbytes - 3'd1;
    end

    // Widened sum exposing the carry past the top of I/O space
    always_comb begin
        last_byte = {1'b0, addr} + {{(AW-2){1'b0}}, nbytes_m1};
        wrap      = last_byte[AW];
    end
endmodule

// File: rtl/iodec_cfg_reg.sv
// Configuration holding register. Reset enables every fixed window and
// clears variable windows and subtractive mode. Assumes cfg_we is a
// synchronous strobe.
module iodec_cfg_reg
    import iodec_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NVAR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [NFIX-1:0]    fix_en_in,
    input  logic [NVAR-1:0]    var_en_in,
    input  logic [NVAR*AW-1:0] var_base_in,
    input  logic               sub_en_in,
    output logic [NFIX-1:0]    fix_en,
    output logic [NVAR-1:0]    var_en,
    output logic [NVAR*AW-1:0] var_base,
    output logic               sub_en
);
    // Load or reset the configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fix_en   <= '1;
            var_en   <= '0;
            var_base <= '0;
            sub_en   <= 1'b0;
        end else if (we) begin
            fix_en   <= fix_en_in;
            var_en   <= var_en_in;
            var_base <= var_base_in;
            sub_en   <= sub_en_in;
        end
    end
endmodule

// File: rtl/iodec_match.sv
// Window matcher: compares a start address with every fixed and variable
// window and picks the winner. Fixed beats variable, and a lower index
// beats a higher one. Variable windows are 2**VSH bytes, aligned.
module iodec_match
    import iodec_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NVAR = 2,
    parameter int VSH  = 4,
    parameter int IW   = 3
) (
    input  logic [AW-1:0]      addr,
    input  logic [NFIX-1:0]    fix_en,
    input  logic [NVAR-1:0]    var_en,
    input  logic [NVAR*AW-1:0] var_base,
    output logic               hit,
    output logic [IW-1:0]      idx,
    output logic               fwd
);
    localparam int NONE = NFIX + NVAR;

    logic [NFIX-1:0] fhit;
    logic [NVAR-1:0] vhit;

    // One comparator pair per fixed window
    for (genvar i = 0; i < NFIX; i++) begin : g_fix
        assign fhit[i] = fix_en[i]
                      && (addr >= AW'(fix_lo(i)))
                      && (addr <= AW'(fix_hi(i)));
    end

    // One aligned equality compare per variable window
    for (genvar j = 0; j < NVAR; j++) begin : g_var
        assign vhit[j] = var_en[j]
                      && (addr[AW-1:VSH] == var_base[j*AW+VSH +: AW-VSH]);
    end

    // Priority pick: scan from weakest to strongest so the strongest wins
    always_comb begin
        hit = 1'b0;
        idx = IW'(NONE);
        fwd = 1'b0;
        for (int j = NVAR - 1; j >= 0; j--) begin
            if (vhit[j]) begin
                hit = 1'b1;
                idx = IW'(NFIX + j);
                fwd = 1'b1;
            end
        end
        for (int i = NFIX - 1; i >= 0; i--) begin
            if (fhit[i]) begin
                hit = 1'b1;
                idx = IW'(i);
                fwd = fix_fwd(i);
            end
        end
    end
endmodule

// File: rtl/iodec_claim_seq.sv
// Claim timing sequencer: latches the decode at the address edge and
// counts edges. It pulses claim at edge 2 for a positive hit, or at edge 4
// for a subtractive claim that no other agent has pre-empted. A new frame
// strobe always restarts it.
module iodec_claim_seq #(
    parameter int IW   = 3,
    parameter int NONE = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          is_io,
    input  logic          dec_hit,
    input  logic [IW-1:0] dec_idx,
    input  logic          dec_fwd,
    input  logic          dec_wrap,
    input  logic          sub_en,
    input  logic          ext_claim,
    output logic          claim,
    output logic [IW-1:0] hit_idx,
    output logic          forward,
    output logic          wrap
);
    localparam logic [2:0] POS_EDGE = 3'd2;
    localparam logic [2:0] SUB_EDGE = 3'd4;

    logic [2:0] age;
    logic       busy;
    logic       pos;
    logic       pfwd;
    logic       supp;
    logic       sub_lat;

    // Frame capture, edge counting and claim generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim   <= 1'b0;
            hit_idx <= IW'(NONE);
            forward <= 1'b0;
            wrap    <= 1'b0;
            age     <= 3'd0;
            busy    <= 1'b0;
            pos     <= 1'b0;
            pfwd    <= 1'b0;
            supp    <= 1'b0;
            sub_lat <= 1'b0;
        end else begin
            claim <= 1'b0;
            if (frame_start) begin
                wrap    <= dec_wrap;
                forward <= 1'b0;
                if (is_io) begin
                    busy    <= 1'b1;
                    age     <= 3'd1;
                    pos     <= dec_hit;
                    pfwd    <= dec_fwd;
                    supp    <= 1'b0;
                    sub_lat <= sub_en;
                    hit_idx <= dec_idx;
                end else begin
                    busy    <= 1'b0;
                    hit_idx <= IW'(NONE);
                end
            end else if (busy) begin
                if (pos && age == POS_EDGE) begin
                    claim   <= 1'b1;
                    forward <= pfwd;
                    busy    <= 1'b0;
                end else if (age == SUB_EDGE) begin
                    busy <= 1'b0;
                    if (!pos && sub_lat && !supp && !ext_claim) begin
                        claim   <= 1'b1;
                        forward <= 1'b1;
                    end
                end else begin
                    age <= age + 3'd1;
                    if (ext_claim) supp <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/io_claim_decoder.sv
// I/O cycle address decoder top. It joins the configuration register, the
// span calculator, the window matcher and the claim sequencer. Assumes
// addr, be and cmd are valid on the frame_start cycle only.
module io_claim_decoder
    import iodec_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NVAR = 2,
    parameter int VSH  = 4,
    localparam int NIDX = NFIX + NVAR + 1,
    localparam int IW   = $clog2(NIDX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [AW-1:0]      addr,
    input  logic [3:0]         be,
    input  logic [3:0]         cmd,
    input  logic               ext_claim,
    input  logic               cfg_we,
    input  logic [NFIX-1:0]    cfg_fix_en,
    input  logic [NVAR-1:0]    cfg_var_en,
    input  logic [NVAR*AW-1:0] cfg_var_base,
    input  logic               cfg_sub_en,
    output logic               claim,
    output logic [IW-1:0]      hit_idx,
    output logic               forward,
    output logic               wrap
);
    logic [NFIX-1:0]    fix_en;
    logic [NVAR-1:0]    var_en;
    logic [NVAR*AW-1:0] var_base;
    logic               sub_en;
    logic [AW:0]        last_byte;
    logic               dec_wrap;
    logic               dec_hit;
    logic [IW-1:0]      dec_idx;
    logic               dec_fwd;
    logic               is_io;

    // Only I/O read and write commands are candidates for a claim
    assign is_io = (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);

    iodec_cfg_reg #(.AW(AW), .NVAR(NVAR)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .fix_en_in   (cfg_fix_en),
        .var_en_in   (cfg_var_en),
        .var_base_in (cfg_var_base),
        .sub_en_in   (cfg_sub_en),
        .fix_en      (fix_en),
        .var_en      (var_en),
        .var_base    (var_base),
        .sub_en      (sub_en)
    );

    iodec_span #(.AW(AW)) u_span (
        .addr      (addr),
        .be        (be),
        .last_byte (last_byte),
        .wrap      (dec_wrap)
    );

    iodec_match #(.AW(AW), .NVAR(NVAR), .VSH(VSH), .IW(IW)) u_match (
        .addr     (addr),
        .fix_en   (fix_en),
        .var_en   (var_en),
        .var_base (var_base),
        .hit      (dec_hit),
        .idx      (dec_idx),
        .fwd      (dec_fwd)
    );

    iodec_claim_seq #(.IW(IW), .NONE(NFIX + NVAR)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .is_io       (is_io),
        .dec_hit     (dec_hit),
        .dec_idx     (dec_idx),
        .dec_fwd     (dec_fwd),
        .dec_wrap    (dec_wrap),
        .sub_en      (sub_en),
        .ext_claim   (ext_claim),
        .claim       (claim),
        .hit_idx     (hit_idx),
        .forward     (forward),
        .wrap        (wrap)
    );

    // The full last-byte address is kept for observation; only its top bit leaves
    logic unused_span;
    assign unused_span = ^last_byte[AW-1:0];
endmodule

// File: rtl/iodec_checker.sv
// Temporal checks on the decoder's ports, attached by bind. Assumes the
// default window numbering (fixed first, then variable, then none).
module iodec_checker #(
    parameter int IW   = 3,
    parameter int NONE = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic [3:0]    cmd,
    input logic          ext_claim,
    input logic          claim,
    input logic [IW-1:0] hit_idx,
    input logic          forward
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!claim && !forward && hit_idx == IW'(NONE))) // R1
        else $error("reset state violated");

    AST_CLAIM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> !claim) // R3
        else $error("claim wider than one cycle");

    AST_POS_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && hit_idx != IW'(NONE)) |-> $past(frame_start, 3)) // R3
        else $error("positive claim at wrong edge");

    AST_SUB_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && hit_idx == IW'(NONE)) |-> ($past(frame_start, 5) && !$past(ext_claim, 1))) // R7
        else $error("subtractive claim at wrong edge or pre-empted");

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_idx <= IW'(NONE)) // R6
        else $error("hit index out of range");

    AST_NONIO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cmd[3:1] != 3'b001) |=> (hit_idx == IW'(NONE) && !claim)) // R10
        else $error("non-I/O frame decoded");

    AST_DMA_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && hit_idx == '0) |-> !forward) // R9
        else $error("window 0 forwarded");
endmodule

bind io_claim_decoder iodec_checker #(.IW(IW), .NONE(iodec_pkg::NFIX + NVAR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cmd         (cmd),
    .ext_claim   (ext_claim),
    .claim       (claim),
    .hit_idx     (hit_idx),
    .forward     (forward)
);

// File: tb/tb_io_claim_decoder.sv
`timescale 1ns/1ps
module tb_io_claim_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [15:0] addr = '0;
    logic [3:0]  be = '0;
    logic [3:0]  cmd = '0;
    logic        ext_claim = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_fix_en = 4'hF;
    logic [1:0]  cfg_var_en = '0;
    logic [31:0] cfg_var_base = '0;
    logic        cfg_sub_en = 1'b0;
    logic        claim;
    logic [2:0]  hit_idx;
    logic        forward;
    logic        wrap;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    io_claim_decoder dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .addr(addr),
        .be(be), .cmd(cmd), .ext_claim(ext_claim), .cfg_we(cfg_we),
        .cfg_fix_en(cfg_fix_en), .cfg_var_en(cfg_var_en),
        .cfg_var_base(cfg_var_base), .cfg_sub_en(cfg_sub_en),
        .claim(claim), .hit_idx(hit_idx), .forward(forward), .wrap(wrap)
    );

    always #2.5 clk = ~clk;

    // ---------------- reference model ----------------
    int m_claim = 0, m_idx = 6, m_fwd = 0, m_wrap = 0;
    int m_age = 0, m_busy = 0, m_pos = 0, m_pfwd = 0, m_supp = 0, m_sub = 0;
    bit [3:0] c_fix = 4'hF;
    bit [1:0] c_ven = 0;
    int c_base[2] = '{0, 0};
    bit c_sub = 0;

    function automatic int win_lo(int i);
        int lo[4] = '{'h000, 'h020, 'h070, 'h0F0};
        return lo[i];
    endfunction
    function automatic int win_hi(int i);
        int hi[4] = '{'h00F, 'h03F, 'h077, 'h0FF};
        return hi[i];
    endfunction

    function automatic int lookup(int a);
        for (int i = 0; i < 4; i++)
            if (c_fix[i] && a >= win_lo(i) && a <= win_hi(i)) return i;
        for (int j = 0; j < 2; j++)
            if (c_ven[j] && (a >> 4) == (c_base[j] >> 4)) return 4 + j;
        return 6;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_claim = 0; m_idx = 6; m_fwd = 0; m_wrap = 0;
            m_busy = 0; m_age = 0; m_pos = 0; m_supp = 0; m_sub = 0;
            c_fix = 4'hF; c_ven = 0; c_base[0] = 0; c_base[1] = 0; c_sub = 0;
        end else begin
            m_claim = 0;
            if (frame_start) begin
                int n;
                int w;
                n = $countones(be);
                if (n == 0) n = 1;
                m_wrap = ((int'(addr) + n - 1) >> 16) & 1;
                m_fwd = 0;
                if (cmd == 4'b0010 || cmd == 4'b0011) begin
                    w = lookup(int'(addr));
                    m_idx = w; m_pos = (w != 6); m_pfwd = (w >= 2);
                    m_busy = 1; m_age = 1; m_supp = 0; m_sub = c_sub;
                end else begin
                    m_busy = 0; m_idx = 6;
                end
            end else if (m_busy) begin
                if (m_pos && m_age == 2) begin
                    m_claim = 1; m_fwd = m_pfwd; m_busy = 0;
                end else if (m_age == 4) begin
                    m_busy = 0;
                    if (!m_pos && m_sub && !m_supp && !ext_claim) begin
                        m_claim = 1; m_fwd = 1;
                    end
                end else begin
                    m_age++;
                    if (ext_claim) m_supp = 1;
                end
            end
            if (cfg_we) begin
                c_fix = cfg_fix_en; c_ven = cfg_var_en;
                c_base[0] = int'(cfg_var_base[15:0]);
                c_base[1] = int'(cfg_var_base[31:16]);
                c_sub = cfg_sub_en;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        chk(int'(claim) == m_claim, "R3 R7 R8 R10 R11 claim", int'(claim), m_claim);
        chk(int'(hit_idx) == m_idx, "R6 hit_idx", int'(hit_idx), m_idx);
        chk(int'(forward) == m_fwd, "R9 forward", int'(forward), m_fwd);
        chk(int'(wrap) == m_wrap, "R2 wrap", int'(wrap), m_wrap);
    end

    // ---------------- stimulus helpers ----------------
    int seen_claims;
    int seen_idx;
    int seen_fwd;

    task automatic set_cfg(input bit [3:0] f, input bit [1:0] v,
                           input bit [15:0] b0, input bit [15:0] b1, input bit s);
        @(negedge clk);
        cfg_we = 1; cfg_fix_en = f; cfg_var_en = v; cfg_var_base = {b1, b0}; cfg_sub_en = s;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic io(input bit [15:0] a, input bit [3:0] b, input bit [3:0] c, input int ext_at);
        seen_claims = 0; seen_idx = 6; seen_fwd = 0;
        @(negedge clk);
        frame_start = 1; addr = a; be = b; cmd = c;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            frame_start = 0;
            ext_claim = (k == ext_at);
            if (claim) begin
                seen_claims++; seen_idx = int'(hit_idx); seen_fwd = int'(forward);
            end
        end
        ext_claim = 0;
    endtask

    // Watchdog
    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!claim && hit_idx == 3'd6 && !forward && !wrap, "R1 reset outputs",
            int'({claim, hit_idx, forward, wrap}), 24);
        rst_n = 1;

        // R3 R9: DMA window claimed locally; window 2 forwarded; bounds
        io(16'h0005, 4'h1, 4'h2, 0);
        chk(seen_claims == 1 && seen_idx == 0 && seen_fwd == 0, "R3 R9 window0", seen_idx, 0);
        io(16'h0077, 4'h3, 4'h3, 0);
        chk(seen_claims == 1 && seen_idx == 2 && seen_fwd == 1, "R9 window2 top", seen_idx, 2);
        io(16'h0078, 4'h1, 4'h2, 0);
        chk(seen_claims == 0, "R4 just past window2", seen_claims, 0);
        io(16'h0020, 4'hF, 4'h2, 2);
        chk(seen_claims == 1 && seen_idx == 1, "R8 positive ignores ext_claim", seen_claims, 1);

        // R2: wrap corner cases
        io(16'hFFFD, 4'hF, 4'h2, 0);
        chk(wrap == 1, "R2 FFFD len4", int'(wrap), 1);
        io(16'hFFFC, 4'hF, 4'h2, 0);
        chk(wrap == 0, "R2 FFFC len4", int'(wrap), 0);
        io(16'hFFFF, 4'h3, 4'h3, 0);
        chk(wrap == 1, "R2 FFFF len2", int'(wrap), 1);
        io(16'hFFFE, 4'h3, 4'h2, 0);
        chk(wrap == 0, "R2 FFFE len2", int'(wrap), 0);
        io(16'hFFFF, 4'h0, 4'h2, 0);
        chk(wrap == 0, "R2 FFFF empty mask", int'(wrap), 0);

        // R4 R12: disable window 0
        set_cfg(4'b1110, 2'b00, 16'h0, 16'h0, 0);
        io(16'h0005, 4'h1, 4'h2, 0);
        chk(seen_claims == 0 && seen_idx == 6, "R4 disabled window0", seen_claims, 0);

        // R5 R6: variable windows, priority, moving
        set_cfg(4'hF, 2'b11, 16'h0300, 16'h0305, 0);
        io(16'h030A, 4'h1, 4'h2, 0);
        chk(seen_claims == 1 && seen_idx == 4 && seen_fwd == 1, "R6 lower variable wins", seen_idx, 4);
        set_cfg(4'hF, 2'b11, 16'h0400, 16'h0020, 0);
        io(16'h0025, 4'h1, 4'h2, 0);
        chk(seen_idx == 1, "R6 fixed beats variable", seen_idx, 1);
        io(16'h030A, 4'h1, 4'h2, 0);
        chk(seen_claims == 0, "R5 moved window no longer at 300h", seen_claims, 0);
        io(16'h040F, 4'h1, 4'h2, 0);
        chk(seen_claims == 1 && seen_idx == 4, "R5 moved window at 400h", seen_idx, 4);
        set_cfg(4'b1101, 2'b10, 16'h0400, 16'h0020, 0);
        io(16'h0025, 4'h1, 4'h2, 0);
        chk(seen_idx == 5, "R6 variable behind disabled fixed", seen_idx, 5);

        // R7 R8: subtractive
        set_cfg(4'hF, 2'b00, 16'h0, 16'h0, 1);
        io(16'h0800, 4'h1, 4'h2, 0);
        chk(seen_claims == 1 && seen_idx == 6 && seen_fwd == 1, "R7 subtractive claim", seen_claims, 1);
        io(16'h0800, 4'h1, 4'h2, 1);
        chk(seen_claims == 0, "R8 ext at edge1", seen_claims, 0);
        io(16'h0800, 4'h1, 4'h2, 4);
        chk(seen_claims == 0, "R8 ext at edge4", seen_claims, 0);
        io(16'h0800, 4'h1, 4'h2, 5);
        chk(seen_claims == 1, "R8 ext after edge4 too late", seen_claims, 1);

        // R10: non-I/O commands
        io(16'h0005, 4'h1, 4'h6, 0);
        chk(seen_claims == 0 && seen_idx == 6, "R10 memory command", seen_claims, 0);
        io(16'h0800, 4'h1, 4'hA, 0);
        chk(seen_claims == 0, "R10 config command", seen_claims, 0);

        // R11: abort by new frame
        @(negedge clk);
        frame_start = 1; addr = 16'h0800; be = 4'h1; cmd = 4'h2;
        @(negedge clk);
        frame_start = 0;
        @(negedge clk);
        frame_start = 1; addr = 16'h0005; be = 4'h1; cmd = 4'h6;
        @(negedge clk);
        frame_start = 0;
        seen_claims = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (claim) seen_claims++;
        end
        chk(seen_claims == 0, "R11 abandoned subtractive", seen_claims, 0);

        // R1 R12: reset restores defaults
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        io(16'h0800, 4'h1, 4'h2, 0);
        chk(seen_claims == 0, "R1 subtractive off after reset", seen_claims, 0);
        io(16'h0005, 4'h1, 4'h2, 0);
        chk(seen_claims == 1 && seen_idx == 0, "R1 fixed enabled after reset", seen_idx, 0);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule